// File: doc/BRIEF.md
# Branch Trace Capture Buffer

This block is a byte-wide ring of storage that sits beside a processor's branch-trace logic. While capture is active it records each accepted trace message byte in the order it arrives. A debug host later stops capture and drains the ring through a read port. The port always starts at the oldest slot, and every read wipes the slot it returns back to 0x00. Draining the whole ring therefore also prepares it for the next capture.

Two capture modes can be chosen each time capture starts. Fill-once mode freezes after the ring holds one full load of bytes. Wrap mode keeps writing and replaces the oldest byte with the newest. The host can tell an unwrapped fill-once capture by the run of zero slots that comes first in age order.

A processor reset only turns capture off. The stored bytes, the pointers and the flags stay as they were, so the trace up to the reset can still be read out.

Top module: `trace_capture_buf`

## Requirements
- R1: While rst_n is low and afterwards until the next start, cap_active and rd_valid are 0 and no byte is stored. Stored bytes, pointers and flags keep their values through reset, so a later read-out returns the trace captured before the reset.
- R2: A cap_start pulse has the following effects from the next cycle:
  - cap_active becomes 1.
  - The mode is taken from cap_wrap (0 = fill-once, 1 = wrap).
  - full and wrapped are cleared.
  - The per-capture byte count and the read-out position restart.
  - A cap_stop pulse makes cap_active 0 from the next cycle; cap_start wins when both are high.
- R3: While cap_active is 1, one byte is stored per cycle when wr_valid=1 and wr_skip=0. A byte with wr_skip=1 (a reset or debug-exception event) is never stored.
- R4: An rd_req taken while cap_active is 0 puts one entry on rd_data with rd_valid=1 in the following cycle, and that slot becomes 0x00. Entries come out oldest first, starting at the slot that the next capture write would use.
- R5: An rd_req taken while cap_active is 1 is ignored: rd_valid stays 0 and no slot changes.
- R6: In fill-once mode, once DEPTH bytes have been stored in the current capture, full becomes 1 and later bytes are dropped.
- R7: In wrap mode, the byte after the first DEPTH bytes overwrites the oldest slot. wrapped becomes 1 at that first overwrite and stays 1 until the next start, including after a stop.
- R8: Bytes are returned in arrival order. For example, the address bytes of an indirect-branch message, pushed before its message byte, are read out before it.
- R9: After DEPTH reads, the write pointer and the read position both return to slot 0. The next read pass starts there and returns 0x00 from the cleared slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low processor reset; disables capture only |
| cap_start | input | 1 | Pulse: enable capture, load mode, clear flags |
| cap_stop | input | 1 | Pulse: disable capture |
| cap_wrap | input | 1 | Mode sampled at start: 0 fill-once, 1 wrap |
| wr_valid | input | 1 | Trace byte present |
| wr_skip | input | 1 | Byte belongs to a reset or debug-exception event; suppress it |
| wr_data | input | DATA_W | Trace byte |
| rd_req | input | 1 | Read strobe; serviced only while capture is off |
| rd_valid | output | 1 | rd_data holds an entry this cycle |
| rd_data | output | DATA_W | Entry read, oldest first |
| cap_active | output | 1 | Capture enabled |
| full | output | 1 | Fill-once capture has filled the ring |
| wrapped | output | 1 | Wrap capture has overwritten an entry (sticky) |

## Verification
The bench drives the ring at its limits:
- Fill-once overfill: one byte past capacity must be dropped. A design that kept writing would show the extra bytes and lose the first ones.
- Wrap overwrite: a design that raised wrapped at exactly DEPTH bytes, or cleared it on stop, fails the flag checks.
- Unwrapped read-out: the bench checks for the leading run of zeros. A read that started at slot 0 instead of the oldest slot would put the zeros last.
- Read strobes during capture, and resets in the middle of a capture: a design that honoured such a strobe, or wiped state on reset, would lose or shift bytes in the next read-out.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
    typedef enum logic {
        TCB_FILL_ONCE = 1'b0,
        TCB_WRAP      = 1'b1
    } tcb_mode_e;
endpackage

// File: rtl/tcb_ring_store.sv
module tcb_ring_store #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    // Storage has no reset: its contents must survive processor reset.
    logic [DATA_W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            slot_q[waddr] <= wdata;
        end
    end

    assign rdata = slot_q[raddr];
endmodule

// File: rtl/tcb_ctrl.sv
module tcb_ctrl
    import tcb_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_start,
    input  logic              cap_stop,
    input  logic              cap_wrap,
    input  logic              wr_valid,
    input  logic              wr_skip,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] st_rdata,
    output logic              st_we,
    output logic [AW-1:0]     st_waddr,
    output logic [DATA_W-1:0] st_wdata,
    output logic [AW-1:0]     st_raddr,
    output logic              rd_last,
    output logic [AW-1:0]     wr_ptr,
    output logic [AW-1:0]     rd_ofs,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              cap_active,
    output logic              full,
    output logic              wrapped
);
    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL  = CW'(DEPTH);
    localparam logic [AW:0]   DEPTH_X   = (AW + 1)'(DEPTH);

    typedef struct packed {
        logic              en;
        tcb_mode_e         mode;
        logic              full;
        logic              wrapped;
        logic [AW-1:0]     wp;
        logic [CW-1:0]     cnt;
        logic [AW-1:0]     rofs;
        logic              rvld;
        logic [DATA_W-1:0] rdat;
    } state_t;

    state_t st_d, st_q;

    logic [AW:0]   rsum;
    logic [AW-1:0] raddr;
    logic          accept;
    logic          rd_fire;

    always_comb begin
        st_d     = st_q;
        st_d.rvld = 1'b0;

        // Oldest slot sits at the write pointer; walk forward from it.
        rsum  = {1'b0, st_q.wp} + {1'b0, st_q.rofs};
        raddr = (rsum >= DEPTH_X) ? AW'(rsum - DEPTH_X) : rsum[AW-1:0];

        accept  = st_q.en && wr_valid && !wr_skip &&
                  !((st_q.mode == TCB_FILL_ONCE) && st_q.full);
        rd_fire = !st_q.en && rd_req;
        rd_last = rd_fire && (st_q.rofs == LAST_SLOT);

        st_we    = 1'b0;
        st_waddr = st_q.wp;
        st_wdata = wr_data;

        if (accept) begin
            st_we    = 1'b1;
            st_d.wp  = (st_q.wp == LAST_SLOT) ? '0 : st_q.wp + 1'b1;
            if (st_q.cnt == CNT_FULL) begin
                st_d.wrapped = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                if ((st_q.mode == TCB_FILL_ONCE) && (st_q.cnt == CNT_FULL - 1'b1)) begin
                    st_d.full = 1'b1;
                end
            end
        end else if (rd_fire) begin
            // Destructive read: clear the slot as it is returned.
            st_we     = 1'b1;
            st_waddr  = raddr;
            st_wdata  = '0;
            st_d.rvld = 1'b1;
            st_d.rdat = st_rdata;
            if (rd_last) begin
                st_d.rofs = '0;
                st_d.wp   = '0;
            end else begin
                st_d.rofs = st_q.rofs + 1'b1;
            end
        end

        if (cap_start) begin
            st_d.en      = 1'b1;
            st_d.mode    = cap_wrap ? TCB_WRAP : TCB_FILL_ONCE;
            st_d.full    = 1'b0;
            st_d.wrapped = 1'b0;
            st_d.cnt     = '0;
            st_d.rofs    = '0;
        end else if (cap_stop) begin
            st_d.en = 1'b0;
        end
    end

    // Reset only disables capture and drops the read response; the rest holds.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en   <= 1'b0;
            st_q.rvld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_raddr   = raddr;
    assign wr_ptr     = st_q.wp;
    assign rd_ofs     = st_q.rofs;
    assign rd_valid   = st_q.rvld;
    assign rd_data    = st_q.rdat;
    assign cap_active = st_q.en;
    assign full       = st_q.full;
    assign wrapped    = st_q.wrapped;
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_start,
    input  logic              cap_stop,
    input  logic              cap_wrap,
    input  logic              wr_valid,
    input  logic              wr_skip,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              cap_active,
    output logic              full,
    output logic              wrapped
);
    localparam int AW = $clog2(DEPTH);

    logic              st_we;
    logic [AW-1:0]     st_waddr;
    logic [DATA_W-1:0] st_wdata;
    logic [AW-1:0]     st_raddr;
    logic [DATA_W-1:0] st_rdata;
    logic              rd_last;
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ofs;

    tcb_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_start  (cap_start),
        .cap_stop   (cap_stop),
        .cap_wrap   (cap_wrap),
        .wr_valid   (wr_valid),
        .wr_skip    (wr_skip),
        .wr_data    (wr_data),
        .rd_req     (rd_req),
        .st_rdata   (st_rdata),
        .st_we      (st_we),
        .st_waddr   (st_waddr),
        .st_wdata   (st_wdata),
        .st_raddr   (st_raddr),
        .rd_last    (rd_last),
        .wr_ptr     (wr_ptr),
        .rd_ofs     (rd_ofs),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .cap_active (cap_active),
        .full       (full),
        .wrapped    (wrapped)
    );

    tcb_ring_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (st_we),
        .waddr (st_waddr),
        .wdata (st_wdata),
        .raddr (st_raddr),
        .rdata (st_rdata)
    );
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker #(
    parameter int AW     = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_start,
    input logic              cap_stop,
    input logic              rd_req,
    input logic              cap_active,
    input logic              full,
    input logic              wrapped,
    input logic              rd_valid,
    input logic              st_we,
    input logic [DATA_W-1:0] st_wdata,
    input logic              rd_last,
    input logic [AW-1:0]     wr_ptr,
    input logic [AW-1:0]     rd_ofs
);
    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_start |=> (cap_active && !full && !wrapped));

    p_stop_disables_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_stop && !cap_start) |=> !cap_active);

    p_idle_only_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && !cap_active) |-> (st_wdata == '0));

    p_read_answers_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !cap_active) |=> rd_valid);

    p_read_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && cap_active) |=> !rd_valid);

    p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && cap_active) |-> !st_we);

    p_wrap_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrapped && !cap_start) |=> wrapped);

    p_ptr_home_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |=> ((wr_ptr == '0) && (rd_ofs == '0)));
endmodule

bind trace_capture_buf tcb_checker #(.AW($clog2(DEPTH)), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_start  (cap_start),
    .cap_stop   (cap_stop),
    .rd_req     (rd_req),
    .cap_active (cap_active),
    .full       (full),
    .wrapped    (wrapped),
    .rd_valid   (rd_valid),
    .st_we      (st_we),
    .st_wdata   (st_wdata),
    .rd_last    (rd_last),
    .wr_ptr     (wr_ptr),
    .rd_ofs     (rd_ofs)
);

// File: tb/trace_capture_buf_bench.sv
module trace_capture_buf_bench;
    localparam int D  = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap_start = 1'b0, cap_stop = 1'b0, cap_wrap = 1'b0;
    logic          wr_valid = 1'b0, wr_skip = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_req = 1'b0;
    logic          rd_valid, cap_active, full, wrapped;
    logic [DW-1:0] rd_data;

    always #2 clk = ~clk;

    trace_capture_buf #(.DEPTH(D), .DATA_W(DW)) u_trace_capture_buf (
        .clk(clk), .rst_n(rst_n), .cap_start(cap_start), .cap_stop(cap_stop),
        .cap_wrap(cap_wrap), .wr_valid(wr_valid), .wr_skip(wr_skip),
        .wr_data(wr_data), .rd_req(rd_req), .rd_valid(rd_valid),
        .rd_data(rd_data), .cap_active(cap_active), .full(full), .wrapped(wrapped)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference model built from the requirements.
    int m_mem [D];
    int m_wp = 0, m_cnt = 0, m_rofs = 0;
    bit m_en = 0, m_wrapmode = 0, m_full = 0, m_wrapped = 0;

    int    exp_q [$];
    string tag_q [$];

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected entries as read responses appear.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R5: unexpected read response actual 1 expected 0");
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e >= 0) check(t, int'(rd_data), e);
            end
        end
    end

    task automatic do_start(bit wrap);
        cap_start = 1'b1; cap_wrap = wrap;
        @(negedge clk);
        cap_start = 1'b0;
        m_en = 1; m_wrapmode = wrap; m_full = 0; m_wrapped = 0; m_cnt = 0; m_rofs = 0;
    endtask

    task automatic do_stop();
        cap_stop = 1'b1;
        @(negedge clk);
        cap_stop = 1'b0;
        m_en = 0;
    endtask

    task automatic push(int b, bit skip);
        wr_valid = 1'b1; wr_data = DW'(b); wr_skip = skip;
        @(negedge clk);
        wr_valid = 1'b0; wr_skip = 1'b0;
        if (m_en && !skip && !(!m_wrapmode && m_full)) begin
            m_mem[m_wp] = b;
            m_wp = (m_wp + 1) % D;
            if (m_cnt == D) m_wrapped = 1;
            else begin
                m_cnt++;
                if (!m_wrapmode && m_cnt == D) m_full = 1;
            end
        end
    endtask

    task automatic read_n(int n, string tag, bit dont_care);
        for (int i = 0; i < n; i++) begin
            int a;
            a = (m_wp + m_rofs) % D;
            exp_q.push_back(dont_care ? -1 : m_mem[a]);
            tag_q.push_back(tag);
            m_mem[a] = 0;
            if (m_rofs == D - 1) begin m_rofs = 0; m_wp = 0; end
            else m_rofs++;
            rd_req = 1'b1;
            @(negedge clk);
        end
        rd_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(tag, exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(cap_active), 0);
        check("R1", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Initialise: one full destructive pass from a known read position.
        do_start(0);
        do_stop();
        read_n(D, "R4", 1);
        for (int i = 0; i < D; i++) m_mem[i] = 0;
        read_n(D, "R4", 0);

        // Fill-once, partial: address bytes then message byte, one skipped byte.
        do_start(0);
        check("R2", int'(cap_active), 1);
        push(8'h11, 0); push(8'h22, 0); push(8'h33, 0); push(8'hA5, 0);
        push(8'hEE, 1);
        do_stop();
        check("R2", int'(cap_active), 0);
        check("R6", int'(full), 0);
        read_n(D, "R8", 0);
        read_n(2, "R9", 0);

        // Reads during capture are ignored.
        do_start(1);
        push(8'h5A, 0);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check("R5", int'(rd_valid), 0);
        push(8'h6B, 0);
        do_stop();
        read_n(D, "R5", 0);

        // Fill-once overfill.
        do_start(0);
        for (int i = 0; i < D - 1; i++) push(8'h40 + i, 0);
        check("R6", int'(full), 0);
        push(8'h40 + D - 1, 0);
        check("R6", int'(full), 1);
        for (int i = 0; i < 3; i++) push(8'hF0 + i, 0);
        do_stop();
        read_n(D, "R6", 0);

        // Wrap mode.
        do_start(1);
        for (int i = 0; i < D; i++) push(8'h80 + i, 0);
        check("R7", int'(wrapped), 0);
        push(8'hC0, 0);
        check("R7", int'(wrapped), 1);
        for (int i = 1; i < 5; i++) push(8'hC0 + i, 0);
        do_stop();
        check("R7", int'(wrapped), 1);
        check("R6", int'(full), 0);
        read_n(D, "R7", 0);
        do_start(0);
        check("R2", int'(wrapped), 0);
        do_stop();

        // Reset in the middle of a capture keeps the trace.
        do_start(0);
        push(8'h91, 0); push(8'h92, 0); push(8'h93, 0);
        rst_n = 1'b0; m_en = 0;
        wr_valid = 1'b1; wr_data = 8'h99;
        @(negedge clk);
        wr_valid = 1'b0;
        check("R1", int'(cap_active), 0);
        check("R1", int'(rd_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push(8'h77, 0);
        check("R1", int'(cap_active), 0);
        check("R1", int'(full), 0);
        read_n(D, "R1", 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule